// File: doc/BRIEF.md
# GPIO Line Event Interrupt Controller

This block watches a set of already-synchronised GPIO input lines. For each line it detects a selectable event and records it in a per-line pending bit. It then drives one shared, active-low interrupt request while any pending bit of an enabled line is set. Software sets the event kind, the enable bit and a hold ("latch") bit for each line through a byte-wide register strobe interface. Software finds the source by reading the pending bits.

A pending bit can be removed in three ways. A read of the captured input port clears every pending bit. A write of ones to the clear register clears single lines. A line whose hold bit is off also clears when its pin returns to the level it had before the event. A second, raw view of the pins can be read at any time and never disturbs pending state. The captured input port holds, for a pending line, the pin value seen at the event. For an idle line it follows the pin.

Registers sit in banks of `2^IDXW` bytes, where `IDXW = clog2(ceil(NUM_LINES/8)) + 1`. The bank number is the three address bits above the byte index, and all higher address bits must be zero. With the default of 16 lines, each bank is 4 bytes long.

Top module: `gpio_irq_top`

## Requirements
- R1: Each line has a 2-bit event kind: 0 is level (a high pin is an event on every cycle), 1 is a rising edge, 2 is a falling edge and 3 is either edge. Edges compare the pin with its value on the previous clock. The kinds are packed four lines per byte in bank 6: line j sits in byte j/4 at bits [2*(j%4)+1 : 2*(j%4)].
- R2: An event sets a line's pending bit only while that line's enable bit (bank 2, bit i%8 of byte i/8) is 1. An event on a disabled line leaves the pending bit at 0.
- R3: A line whose hold bit (bank 3) is 1 keeps its pending bit after the pin returns. The bit stays set until an input-port read or a clear write.
- R4: A pending line whose hold bit is 0 clears one clock after its pin differs from the value captured at the event. The exception is when that same transition is itself a selected event, as with the either-edge kind.
- R5: After reset all enable bits, hold bits, event kinds and pending bits are 0, irq_n is 1 and rdata is 0.
- R6: Writing a byte to the clear bank (bank 5) clears the pending bit of each line whose bit in that byte is 1. The other lines are left unchanged, and the bank reads as 0.
- R7: Bank 1 returns the live pin values and never changes any pending bit.
- R8: Bank 0 returns each pending line's pin value captured at its event, and each idle line's pin value from the previous clock. A read of bank 0 clears all pending bits at the clock edge of the read strobe. The read data of any bank appears on rdata on the clock after rd_en.
- R9: irq_n is registered. It is 0 on the clock after any line is both pending and enabled, and it returns to 1 on the clock after the last such line clears.
- R10: An event on a line in the same clock as any clear of that line leaves the pending bit set.
- R11: Bank 4 returns the pending bits. Byte indexes beyond the bank's width, bank 7, and addresses with nonzero upper bits read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins | input | NUM_LINES | Synchronised GPIO input levels |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address: upper bits zero, 3-bit bank, IDXW-bit byte index |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data byte, valid the clock after rd_en |
| irq_n | output | 1 | Shared active-low interrupt request |

## Verification
The bound checker checks these properties on every cycle:
- irq_n always equals the registered OR of the enabled pending bits.
- No pending bit rises on a line that was disabled in the cycle before.
- A held pending bit never drops in a cycle without a strobe.
- A raw-view read never clears held pending bits.

Other behaviour depends on pin histories, so only the directed scenarios can show it:
- Which transitions count as events for each kind.
- The value captured in the port view.
- Auto-clear on the return of the pin, and the special case of the either-edge kind.
- The clear-versus-event collision, and the ignoring of out-of-range addresses.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    EV_LEVEL = 2'd0,
    EV_RISE  = 2'd1,
    EV_FALL  = 2'd2,
    EV_ANY   = 2'd3
  } ev_kind_e;

  typedef enum logic [2:0] {
    BK_PORT  = 3'd0,
    BK_RAW   = 3'd1,
    BK_MASK  = 3'd2,
    BK_HOLD  = 3'd3,
    BK_PEND  = 3'd4,
    BK_CLR   = 3'd5,
    BK_EVSEL = 3'd6,
    BK_RSVD  = 3'd7
  } bank_e;

endpackage

// File: rtl/gpio_irq_line.sv
module gpio_irq_line
  import gpio_irq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin,
  input  ev_kind_e ev_sel,
  input  logic     mask_en,
  input  logic     hold_en,
  input  logic     clr_req,
  output logic     pend,
  output logic     cap
);

  logic prev_q, pend_q, cap_q;
  logic pend_d, cap_d;
  logic hit, hit_en, drop;

  // event detection against the previous-clock pin value
  always_comb begin
    unique case (ev_sel)
      EV_LEVEL: hit = pin;
      EV_RISE:  hit = pin & ~prev_q;
      EV_FALL:  hit = ~pin & prev_q;
      default:  hit = pin ^ prev_q;
    endcase
    hit_en = hit & mask_en;
    // unheld lines drop when the pin leaves the captured event level
    drop   = clr_req | (~hold_en & pend_q & (pin != cap_q));
  end

  always_comb begin
    pend_d = pend_q;
    cap_d  = cap_q;
    if (drop) begin
      pend_d = 1'b0;
    end
    if (hit_en) begin
      pend_d = 1'b1;
      cap_d  = pin;
    end else if (!pend_q) begin
      cap_d  = pin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
      cap_q  <= 1'b0;
    end else begin
      prev_q <= pin;
      pend_q <= pend_d;
      cap_q  <= cap_d;
    end
  end

  assign pend = pend_q;
  assign cap  = cap_q;

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic                   rd_en,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [7:0]             wdata,
  input  logic [NUM_LINES-1:0]   pins,
  input  logic [NUM_LINES-1:0]   pend,
  input  logic [NUM_LINES-1:0]   cap,
  output logic [NUM_LINES-1:0]   mask_vec,
  output logic [NUM_LINES-1:0]   hold_vec,
  output logic [2*NUM_LINES-1:0] ev_vec,
  output logic [NUM_LINES-1:0]   clr_vec,
  output logic                   port_rd_clr,
  output logic [7:0]             rdata
);

  localparam int NPORT = (NUM_LINES + 7) / 8;
  localparam int IDXW  = $clog2(NPORT) + 1;
  localparam int PAD   = NPORT * 8;
  localparam int EVW   = 2 * PAD;
  localparam int NEVB  = 2 * NPORT;
  localparam logic [PAD-1:0] LINE_OK = PAD'({NUM_LINES{1'b1}});
  localparam logic [EVW-1:0] EV_OK   = EVW'({2*NUM_LINES{1'b1}});

  logic [PAD-1:0] mask_q, mask_d;
  logic [PAD-1:0] hold_q, hold_d;
  logic [EVW-1:0] ev_q, ev_d;
  logic [PAD-1:0] clr_pad;
  logic [7:0]     rdata_q, rdata_d;
  logic [PAD-1:0] pin_pad, pend_pad, cap_pad;

  logic            addr_ok;
  bank_e           bank;
  logic [IDXW-1:0] idx;
  logic            port_ok;

  assign pin_pad  = PAD'(pins);
  assign pend_pad = PAD'(pend);
  assign cap_pad  = PAD'(cap);

  // address decode
  always_comb begin
    addr_ok = ((addr >> (IDXW + 3)) == '0);
    bank    = bank_e'(addr[IDXW+2:IDXW]);
    idx     = addr[IDXW-1:0];
    port_ok = (idx < IDXW'(NPORT));
  end

  // configuration next state and per-line clear pulses
  always_comb begin
    mask_d  = mask_q;
    hold_d  = hold_q;
    ev_d    = ev_q;
    clr_pad = '0;
    if (wr_en && addr_ok) begin
      for (int p = 0; p < NPORT; p++) begin
        if (idx == IDXW'(p)) begin
          unique case (bank)
            BK_MASK: mask_d[p*8 +: 8]  = wdata & LINE_OK[p*8 +: 8];
            BK_HOLD: hold_d[p*8 +: 8]  = wdata & LINE_OK[p*8 +: 8];
            BK_CLR:  clr_pad[p*8 +: 8] = wdata & LINE_OK[p*8 +: 8];
            default: ;
          endcase
        end
      end
      for (int b = 0; b < NEVB; b++) begin
        if (bank == BK_EVSEL && idx == IDXW'(b)) begin
          ev_d[b*8 +: 8] = wdata & EV_OK[b*8 +: 8];
        end
      end
    end
  end

  assign port_rd_clr = rd_en & addr_ok & (bank == BK_PORT) & port_ok;

  // read mux
  always_comb begin
    rdata_d = 8'h00;
    if (addr_ok) begin
      for (int p = 0; p < NPORT; p++) begin
        if (idx == IDXW'(p)) begin
          unique case (bank)
            BK_PORT: rdata_d = cap_pad[p*8 +: 8];
            BK_RAW:  rdata_d = pin_pad[p*8 +: 8];
            BK_MASK: rdata_d = mask_q[p*8 +: 8];
            BK_HOLD: rdata_d = hold_q[p*8 +: 8];
            BK_PEND: rdata_d = pend_pad[p*8 +: 8];
            default: ;
          endcase
        end
      end
      for (int b = 0; b < NEVB; b++) begin
        if (bank == BK_EVSEL && idx == IDXW'(b)) begin
          rdata_d = ev_q[b*8 +: 8];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      hold_q  <= '0;
      ev_q    <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_en) begin
        mask_q <= mask_d;
        hold_q <= hold_d;
        ev_q   <= ev_d;
      end
      if (rd_en) begin
        rdata_q <= rdata_d;
      end
    end
  end

  assign mask_vec = mask_q[NUM_LINES-1:0];
  assign hold_vec = hold_q[NUM_LINES-1:0];
  assign ev_vec   = ev_q[2*NUM_LINES-1:0];
  assign clr_vec  = clr_pad[NUM_LINES-1:0];
  assign rdata    = rdata_q;

endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] pins,
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic                 irq_n
);

  logic                   rst_meta_q, rst_sync_n;
  logic [NUM_LINES-1:0]   mask_vec, hold_vec, clr_vec, pend_vec, cap_vec;
  logic [2*NUM_LINES-1:0] ev_vec;
  logic                   port_rd_clr;
  logic                   irq_n_q, irq_n_d;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  gpio_irq_regs #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .pins        (pins),
    .pend        (pend_vec),
    .cap         (cap_vec),
    .mask_vec    (mask_vec),
    .hold_vec    (hold_vec),
    .ev_vec      (ev_vec),
    .clr_vec     (clr_vec),
    .port_rd_clr (port_rd_clr),
    .rdata       (rdata)
  );

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    gpio_irq_line u_line (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .pin     (pins[i]),
      .ev_sel  (ev_kind_e'(ev_vec[2*i +: 2])),
      .mask_en (mask_vec[i]),
      .hold_en (hold_vec[i]),
      .clr_req (clr_vec[i] | port_rd_clr),
      .pend    (pend_vec[i]),
      .cap     (cap_vec[i])
    );
  end

  always_comb begin
    irq_n_d = ~|(pend_vec & mask_vec);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      irq_n_q <= 1'b1;
    end else begin
      irq_n_q <= irq_n_d;
    end
  end

  assign irq_n = irq_n_q;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NUM_LINES = 16,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_en,
  input logic                 rd_en,
  input logic [ADDR_W-1:0]    addr,
  input logic                 irq_n,
  input logic [NUM_LINES-1:0] pend,
  input logic [NUM_LINES-1:0] mask,
  input logic [NUM_LINES-1:0] hold
);

  localparam int NPORT = (NUM_LINES + 7) / 8;
  localparam int IDXW  = $clog2(NPORT) + 1;

  logic raw_sel;
  assign raw_sel = ((addr >> (IDXW + 3)) == '0) && (addr[IDXW+2:IDXW] == 3'd1);

  // R9: request level is the registered OR of enabled pending lines
  p_irq_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_n == ~|($past(pend) & $past(mask)));

  // R2: a pending bit only rises on a line that was enabled
  p_mask_gates_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pend & ~$past(pend) & ~$past(mask)) == '0);

  // R3: held pending bits survive any cycle without a strobe
  p_hold_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> (($past(pend) & $past(hold) & ~pend) == '0));

  // R7: a raw-view read leaves held pending bits in place
  p_raw_read_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && raw_sel) |=> (($past(pend) & $past(hold) & ~pend) == '0));

endmodule

bind gpio_irq_top gpio_irq_chk #(
  .NUM_LINES (NUM_LINES),
  .ADDR_W    (ADDR_W)
) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .wr_en (wr_en),
  .rd_en (rd_en),
  .addr  (addr),
  .irq_n (irq_n),
  .pend  (pend_vec),
  .mask  (mask_vec),
  .hold  (hold_vec)
);

// File: tb/tb_gpio_irq_top.sv
module tb_gpio_irq_top;

  logic        clk;
  logic        rst_n;
  logic [15:0] pins;
  logic        wr_en, rd_en;
  logic [7:0]  addr, wdata;
  logic [7:0]  rdata;
  logic        irq_n;

  int n_chk  = 0;
  int n_fail = 0;
  logic [7:0] rv;

  gpio_irq_top #(.NUM_LINES(16), .ADDR_W(8)) dut (
    .clk(clk), .rst_n(rst_n), .pins(pins), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq_n(irq_n)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk);
    pins = v;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic quiesce();
    wr(8'h08, 8'h00); wr(8'h09, 8'h00);
    set_pins(16'h0000); idle(2);
    wr(8'h0C, 8'h00); wr(8'h0D, 8'h00);
    wr(8'h14, 8'hFF); wr(8'h15, 8'hFF);
    for (int b = 0; b < 4; b++) wr(8'h18 + 8'(b), 8'h00);
  endtask

  task automatic t_reset();
    chk("R5 irq_n after reset", {7'd0, irq_n}, 8'h01);
    chk("R5 rdata after reset", rdata, 8'h00);
    rd(8'h08, rv); chk("R5 mask0 reset", rv, 8'h00);
    rd(8'h09, rv); chk("R5 mask1 reset", rv, 8'h00);
    rd(8'h0C, rv); chk("R5 hold0 reset", rv, 8'h00);
    rd(8'h18, rv); chk("R5 evsel reset", rv, 8'h00);
    rd(8'h10, rv); chk("R5 pending reset", rv, 8'h00);
  endtask

  task automatic t_rising();
    quiesce();
    wr(8'h18, 8'h01); wr(8'h08, 8'h01);
    set_pins(16'h0001);
    @(negedge clk); chk("R9 irq_n not yet low", {7'd0, irq_n}, 8'h01);
    @(negedge clk); chk("R9 irq_n low one clock later", {7'd0, irq_n}, 8'h00);
    rd(8'h10, rv); chk("R1 rising sets pending", rv, 8'h01);
    rd(8'h04, rv); chk("R7 raw view", rv, 8'h01);
    rd(8'h10, rv); chk("R7 raw read keeps pending", rv, 8'h01);
    set_pins(16'h0000); idle(1);
    rd(8'h10, rv); chk("R4 unheld rising auto-clear", rv, 8'h00);
    chk("R9 irq_n released", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_falling();
    quiesce();
    wr(8'h18, 8'h09); wr(8'h08, 8'h02);
    set_pins(16'h0002); idle(2);
    rd(8'h10, rv); chk("R1 falling ignores rise", rv, 8'h00);
    set_pins(16'h0000); idle(2);
    rd(8'h10, rv); chk("R1 falling sets pending", rv, 8'h02);
    set_pins(16'h0001); idle(2);
    rd(8'h10, rv); chk("R2 disabled line stays clear", rv, 8'h02);
    set_pins(16'h0003); idle(2);
    rd(8'h10, rv); chk("R4 unheld falling auto-clear", rv, 8'h00);
  endtask

  task automatic t_hold_port();
    quiesce();
    wr(8'h18, 8'h10); wr(8'h0C, 8'h04); wr(8'h08, 8'h04);
    set_pins(16'h0004); idle(2);
    set_pins(16'h0000); idle(2);
    rd(8'h10, rv); chk("R3 held pending survives return", rv, 8'h04);
    chk("R3 irq_n still low", {7'd0, irq_n}, 8'h00);
    rd(8'h00, rv); chk("R8 port shows captured level", rv, 8'h04);
    rd(8'h10, rv); chk("R8 port read clears pending", rv, 8'h00);
    chk("R9 irq_n high after port read", {7'd0, irq_n}, 8'h01);
    set_pins(16'h0020); idle(2);
    rd(8'h00, rv); chk("R8 idle line follows pin", rv, 8'h20);
  endtask

  task automatic t_clear();
    quiesce();
    wr(8'h0D, 8'h03); wr(8'h09, 8'h03);
    set_pins(16'h0300); idle(2);
    set_pins(16'h0000); idle(2);
    rd(8'h11, rv); chk("R1 level held pending", rv, 8'h03);
    wr(8'h15, 8'h01);
    rd(8'h11, rv); chk("R6 clear one line only", rv, 8'h02);
    chk("R6 irq_n still low", {7'd0, irq_n}, 8'h00);
    rd(8'h15, rv); chk("R6 clear bank reads zero", rv, 8'h00);
    wr(8'h15, 8'h02);
    rd(8'h11, rv); chk("R6 clear second line", rv, 8'h00);
    chk("R6 irq_n high", {7'd0, irq_n}, 8'h01);
  endtask

  task automatic t_collide();
    quiesce();
    wr(8'h09, 8'h04);
    set_pins(16'h0400); idle(2);
    wr(8'h15, 8'h04);
    rd(8'h11, rv); chk("R10 level clear with pin high", rv, 8'h04);
    set_pins(16'h0000); idle(1);
    rd(8'h11, rv); chk("R4 level unheld auto-clear", rv, 8'h00);
    wr(8'h1A, 8'h40); wr(8'h0D, 8'h08); wr(8'h09, 8'h0C);
    @(negedge clk);
    pins = 16'h0800; wr_en = 1'b1; addr = 8'h15; wdata = 8'h08;
    @(negedge clk);
    wr_en = 1'b0;
    rd(8'h11, rv); chk("R10 edge and clear same clock", rv, 8'h08);
  endtask

  task automatic t_any();
    quiesce();
    wr(8'h18, 8'hC0); wr(8'h0C, 8'h08); wr(8'h08, 8'h08);
    set_pins(16'h0008); idle(2);
    rd(8'h10, rv); chk("R1 any-edge rise", rv, 8'h08);
    wr(8'h14, 8'h08);
    rd(8'h10, rv); chk("R6 cleared before fall", rv, 8'h00);
    set_pins(16'h0000); idle(2);
    rd(8'h10, rv); chk("R1 any-edge fall", rv, 8'h08);
  endtask

  task automatic t_map();
    quiesce();
    wr(8'h19, 8'hA5);
    rd(8'h19, rv); chk("R11 event byte readback", rv, 8'hA5);
    rd(8'h1C, rv); chk("R11 reserved bank reads zero", rv, 8'h00);
    rd(8'h02, rv); chk("R11 out-of-range index reads zero", rv, 8'h00);
    wr(8'h08, 8'h5A);
    wr(8'h0A, 8'hFF);
    wr(8'h88, 8'hFF);
    rd(8'h08, rv); chk("R11 stray writes ignored", rv, 8'h5A);
    rd(8'h09, rv); chk("R11 mask1 untouched", rv, 8'h00);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; pins = '0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(3);
    t_reset();
    t_rising();
    t_falling();
    t_hold_port();
    t_clear();
    t_collide();
    t_any();
    t_map();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule